// File: doc/BRIEF.md
# IDE Register Window Bridge

This block turns a 4 KiB memory-mapped window into cycles on a simple IDE task-file bus. A host sends a request carrying a byte address, an access size code, a read/write flag and write data. The block works out which register the address selects, checks whether that register allows the requested size, and then does one of three things. It strobes the task-file bus, it services one of its two local registers, or it treats the access as open bus.

The two local registers are a free-form 32-bit timing word and an interrupt status word. The status word mirrors the two interrupt request lines, one from the DMA channel and one from the drive. Both request lines are also passed straight through to output pins. The drive sits behind the task-file port, and the port assumes a one-cycle access.

Requests use a valid/ready handshake. Every accepted read produces exactly one response on a valid/ready output, one cycle after it is accepted. `req_ready` drops only while a finished read response is waiting and `rsp_ready` is low. Write requests produce no response.

Top module: `ide_window_bridge`

## Requirements
- R1: The register index is the 12-bit byte address shifted right by 4, so address bits 3:0 never change which register is selected.
- R2: Index 0 is the data port. Reads of 1, 2 or 4 bytes strobe `tf_rd` with `tf_idx`=0. `tf_dword` is 1 only for 4 bytes. The response is the low 8 bits, the low 16 bits or all 32 bits of `tf_rdata`, zero-extended.
- R3: A write to index 0 strobes `tf_wr` only for 2 bytes (`tf_dword`=0) or 4 bytes (`tf_dword`=1), with `tf_wdata` equal to the request data. A 1-byte write to index 0 produces no strobe.
- R4: Indices 1 to 7 strobe the task-file bus with `tf_idx` equal to the index and `tf_sel_ctl`=0, for 1-byte accesses only. A read returns `tf_rdata[7:0]` zero-extended.
- R5: Indices 8 and 22 both select the control block (`tf_sel_ctl`=1, `tf_idx`=0). A read reaches the status register and a write reaches the device-control register, for 1-byte accesses only.
- R6: Index 32 is a 32-bit timing word that is read and written only with 4-byte accesses.
- R7: Index 48 is the interrupt word, accessed only at 4 bytes. Bit 31 holds the DMA line and bit 30 holds the drive line; all other bits read 0. Bit 30 follows the drive level one cycle later. Bit 31 takes the DMA level one cycle after that level changes. Writing a value with bit 31 set clears bit 31, unless the DMA level changes in the same cycle. No other written bit has any effect.
- R8: `dma_irq_out` equals `dma_irq_in` and `drv_irq_out` equals `drv_irq_in` in the same cycle.
- R9: A read of an unmapped index, or at a size the register does not allow, returns 0xFFFFFFFF and causes no strobe. A write under the same conditions causes no strobe and changes no register.
- R10: While reset is held, and for the first cycle after it is released, `tf_rst` is 1. The timing and interrupt words reset to 0, and no response is pending.
- R11: A read accepted in cycle T has its response valid in cycle T+1. A response held with `rsp_ready` low keeps its data stable and holds `req_ready` low. Task-file strobes occur only in a cycle where a request is accepted.

Size codes on `req_size`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = never allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address inside the window |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 32 | Read response data |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_sel_ctl | output | 1 | Selects status (read) or device control (write) |
| tf_idx | output | 3 | Task-file register number |
| tf_dword | output | 1 | 32-bit data-port access |
| tf_wdata | output | 32 | Task-file write data |
| tf_rdata | input | 32 | Task-file read data, valid with tf_rd |
| tf_rst | output | 1 | Reset to the task-file bus |
| dma_irq_in | input | 1 | DMA channel interrupt request |
| drv_irq_in | input | 1 | Drive interrupt request |
| dma_irq_out | output | 1 | Forwarded DMA interrupt |
| drv_irq_out | output | 1 | Forwarded drive interrupt |

## Verification
Each result has a fixed latency, and every check samples at that point on a falling clock edge. Task-file strobes and the forwarded interrupt lines are combinational, so they are checked one time step after the inputs are driven, before the accepting edge. Read data comes one cycle after acceptance, and a monitor compares it against a queue filled by the driver when the request was accepted. Register and interrupt-word changes take one cycle, so the read that checks them is issued only after that edge has passed.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_DATA   = 3'd1,
    TGT_TASK   = 3'd2,
    TGT_CTL    = 3'd3,
    TGT_TIMING = 3'd4,
    TGT_IRQ    = 3'd5
  } target_e;

  localparam int IDX_DATA     = 0;
  localparam int IDX_TASK_LO  = 1;
  localparam int IDX_TASK_HI  = 7;
  localparam int IDX_CTL_A    = 8;
  localparam int IDX_CTL_B    = 22;
  localparam int IDX_TIMING   = 32;
  localparam int IDX_IRQ      = 48;
  localparam logic [31:0] OPEN_BUS = 32'hFFFF_FFFF;

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_win_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int STRIDE_LSB = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  input  logic              write,
  output target_e           target,
  output logic [2:0]        tf_idx,
  output logic              dword
);

  localparam int IDX_W = ADDR_W - STRIDE_LSB;

  logic [IDX_W-1:0] reg_idx;
  target_e          raw_tgt;
  logic             size_ok;

  assign reg_idx = addr[ADDR_W-1:STRIDE_LSB];

  always_comb begin
    raw_tgt = TGT_NONE;
    size_ok = 1'b0;
    tf_idx  = 3'd0;
    dword   = 1'b0;
    if (int'(reg_idx) == IDX_DATA) begin
      raw_tgt = TGT_DATA;
      dword   = (size == SZ_WORD);
      if (write) size_ok = (size == SZ_HALF) || (size == SZ_WORD);
      else       size_ok = (size != SZ_BAD);
    end else if (int'(reg_idx) >= IDX_TASK_LO && int'(reg_idx) <= IDX_TASK_HI) begin
      raw_tgt = TGT_TASK;
      tf_idx  = reg_idx[2:0];
      size_ok = (size == SZ_BYTE);
    end else if (int'(reg_idx) == IDX_CTL_A || int'(reg_idx) == IDX_CTL_B) begin
      raw_tgt = TGT_CTL;
      size_ok = (size == SZ_BYTE);
    end else if (int'(reg_idx) == IDX_TIMING) begin
      raw_tgt = TGT_TIMING;
      size_ok = (size == SZ_WORD);
    end else if (int'(reg_idx) == IDX_IRQ) begin
      raw_tgt = TGT_IRQ;
      size_ok = (size == SZ_WORD);
    end
    target = size_ok ? raw_tgt : TGT_NONE;
  end

endmodule

// File: rtl/ide_win_word_reg.sv
module ide_win_word_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  AST_TIMING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R6

endmodule

// File: rtl/ide_win_irq_status.sv
module ide_win_irq_status #(
  parameter int NUM_LINES = 2,
  parameter int W         = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lvl,
  input  logic                 clr_top,
  output logic [W-1:0]         q
);

  localparam int LOW_BITS = W - NUM_LINES;

  assign q[LOW_BITS-1:0] = '0;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic bit_q;
    assign q[W-1-n] = bit_q;

    if (n == 0) begin : g_latched
      logic prev_lvl;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q    <= 1'b0;
          prev_lvl <= 1'b0;
        end else begin
          prev_lvl <= lvl[n];
          if (lvl[n] != prev_lvl) bit_q <= lvl[n];
          else if (clr_top)       bit_q <= 1'b0;
        end
      end

      AST_TOP_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[n] != prev_lvl) |=> (bit_q == $past(lvl[n]))); // R7
      AST_TOP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_top && lvl[n] == prev_lvl) |=> !bit_q); // R7
    end else begin : g_mirror
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= lvl[n];
      end

      AST_LINE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bit_q == $past(lvl[n]))); // R7
    end
  end

endmodule

// File: rtl/ide_window_bridge.sv
module ide_window_bridge
  import ide_win_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int STRIDE_LSB = 4,
  parameter int DATA_W     = 32,
  parameter int NUM_IRQ    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic              tf_sel_ctl,
  output logic [2:0]        tf_idx,
  output logic              tf_dword,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata,
  output logic              tf_rst,
  input  logic              dma_irq_in,
  input  logic              drv_irq_in,
  output logic              dma_irq_out,
  output logic              drv_irq_out
);

  localparam int TOP_BIT = DATA_W - 1;

  acc_size_e         size_c;
  target_e           target;
  logic [2:0]        dec_idx;
  logic              dec_dword;
  logic              accept;
  logic              is_bus;
  logic              timing_we;
  logic              irq_clr;
  logic [DATA_W-1:0] timing_q;
  logic [DATA_W-1:0] irq_q;
  logic [DATA_W-1:0] rd_mux;
  logic [NUM_IRQ-1:0] irq_lvl;
  logic              tf_rst_q;

  assign size_c = acc_size_e'(req_size);

  ide_win_decode #(
    .ADDR_W    (ADDR_W),
    .STRIDE_LSB(STRIDE_LSB)
  ) u_decode (
    .addr  (req_addr),
    .size  (size_c),
    .write (req_write),
    .target(target),
    .tf_idx(dec_idx),
    .dword (dec_dword)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign is_bus    = (target == TGT_DATA) || (target == TGT_TASK) || (target == TGT_CTL);

  assign tf_rd      = accept && !req_write && is_bus;
  assign tf_wr      = accept &&  req_write && is_bus;
  assign tf_sel_ctl = (target == TGT_CTL);
  assign tf_idx     = dec_idx;
  assign tf_dword   = dec_dword && (target == TGT_DATA);
  assign tf_wdata   = req_wdata;

  assign timing_we = accept && req_write && (target == TGT_TIMING);
  assign irq_clr   = accept && req_write && (target == TGT_IRQ) && req_wdata[TOP_BIT];

  ide_win_word_reg #(.W(DATA_W)) u_timing (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (timing_we),
    .d    (req_wdata),
    .q    (timing_q)
  );

  assign irq_lvl = {drv_irq_in, dma_irq_in};

  ide_win_irq_status #(
    .NUM_LINES(NUM_IRQ),
    .W        (DATA_W)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (irq_lvl),
    .clr_top(irq_clr),
    .q      (irq_q)
  );

  assign dma_irq_out = dma_irq_in;
  assign drv_irq_out = drv_irq_in;

  always_comb begin
    rd_mux = OPEN_BUS;
    unique case (target)
      TGT_DATA: begin
        unique case (size_c)
          SZ_BYTE: rd_mux = {{(DATA_W-8){1'b0}}, tf_rdata[7:0]};
          SZ_HALF: rd_mux = {{(DATA_W-16){1'b0}}, tf_rdata[15:0]};
          default: rd_mux = tf_rdata;
        endcase
      end
      TGT_TASK,
      TGT_CTL:    rd_mux = {{(DATA_W-8){1'b0}}, tf_rdata[7:0]};
      TGT_TIMING: rd_mux = timing_q;
      TGT_IRQ:    rd_mux = irq_q;
      default:    rd_mux = OPEN_BUS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tf_rst_q <= 1'b1;
    else        tf_rst_q <= 1'b0;
  end
  assign tf_rst = tf_rst_q;

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    tf_rd |=> rsp_valid); // R11
  AST_NO_STROBE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (!tf_rd && !tf_wr)); // R11
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tf_rd && tf_wr)); // R4
  AST_DWORD_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_dword && (tf_rd || tf_wr)) |-> (tf_idx == 3'd0 && !tf_sel_ctl)); // R2
  AST_TFRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tf_rst |=> !tf_rst); // R10
  AST_IRQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_irq_out == dma_irq_in) && (drv_irq_out == drv_irq_in)); // R8

endmodule

// File: tb/sim_ide_window_bridge.sv
module sim_ide_window_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        tf_rd, tf_wr, tf_sel_ctl, tf_dword, tf_rst;
  logic [2:0]  tf_idx;
  logic [31:0] tf_wdata;
  logic [31:0] tf_rdata;
  logic        dma_irq_in = 1'b0;
  logic        drv_irq_in = 1'b0;
  logic        dma_irq_out, drv_irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  // drive stand-in: pattern depends on the selected register
  assign tf_rdata = {16'hCAFE, 4'h7, tf_sel_ctl, tf_idx, 4'hB, tf_sel_ctl, tf_idx};

  ide_window_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_sel_ctl(tf_sel_ctl), .tf_idx(tf_idx),
    .tf_dword(tf_dword), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .tf_rst(tf_rst),
    .dma_irq_in(dma_irq_in), .drv_irq_in(drv_irq_in),
    .dma_irq_out(dma_irq_out), .drv_irq_out(drv_irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: issues one request, checks strobes, queues expected read data
  task automatic access(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input bit e_rd, input bit e_wr,
                        input bit e_ctl, input logic [2:0] e_idx, input bit e_dw,
                        input logic [31:0] e_rdata, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    chk({req, " strobes"}, {30'd0, tf_rd, tf_wr}, {30'd0, e_rd, e_wr});
    if (e_rd || e_wr) begin
      chk({req, " sel/idx/dword"}, {27'd0, tf_sel_ctl, tf_idx, tf_dword},
          {27'd0, e_ctl, e_idx, e_dw});
      if (e_wr) chk({req, " wdata"}, tf_wdata, wd);
    end
    if (!wr) begin
      exp_q.push_back(e_rdata);
      tag_q.push_back(req);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // monitor: compares each delivered read response with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected response", rsp_data, 32'hXXXX_XXXX);
      end else begin
        chk({tag_q.pop_front(), " rdata"}, rsp_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R10 reset behaviour
    repeat (3) @(negedge clk);
    chk("R10 tf_rst during reset", {31'd0, tf_rst}, 32'd1);
    rst_n = 1'b1;
    #1 chk("R10 tf_rst first cycle", {31'd0, tf_rst}, 32'd1);
    chk("R10 no response", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    #1 chk("R10 tf_rst released", {31'd0, tf_rst}, 32'd0);
    access(0, 12'h200, 2'd2, 0, 0, 0, 0, 0, 0, 32'h0, "R10 timing reset");
    access(0, 12'h300, 2'd2, 0, 0, 0, 0, 0, 0, 32'h0, "R10 irq reset");

    // R2 data port reads
    access(0, 12'h000, 2'd0, 0, 1, 0, 0, 3'd0, 0, 32'h0000_00B0, "R2 byte read");
    access(0, 12'h000, 2'd1, 0, 1, 0, 0, 3'd0, 0, 32'h0000_70B0, "R2 half read");
    access(0, 12'h000, 2'd2, 0, 1, 0, 0, 3'd0, 1, 32'hCAFE_70B0, "R2 word read");
    // R1 low address bits ignored
    access(0, 12'h00C, 2'd1, 0, 1, 0, 0, 3'd0, 0, 32'h0000_70B0, "R1 offset C");
    access(0, 12'h03F, 2'd0, 0, 1, 0, 0, 3'd3, 0, 32'h0000_00B3, "R1 offset 3F");

    // R3 data port writes
    access(1, 12'h002, 2'd1, 32'h1234_ABCD, 0, 1, 0, 3'd0, 0, 0, "R3 half write");
    access(1, 12'h000, 2'd2, 32'h5566_7788, 0, 1, 0, 3'd0, 1, 0, "R3 word write");
    access(1, 12'h000, 2'd0, 32'h0000_0011, 0, 0, 0, 3'd0, 0, 0, "R3 byte write ignored");

    // R4 task-file registers
    access(0, 12'h050, 2'd0, 0, 1, 0, 0, 3'd5, 0, 32'h0000_00B5, "R4 byte read idx5");
    access(1, 12'h070, 2'd0, 32'h0000_00EC, 0, 1, 0, 3'd7, 0, 0, "R4 byte write idx7");
    access(0, 12'h050, 2'd1, 0, 0, 0, 0, 3'd0, 0, 32'hFFFF_FFFF, "R4 half read refused");

    // R5 status / control alias
    access(0, 12'h080, 2'd0, 0, 1, 0, 1, 3'd0, 0, 32'h0000_00B8, "R5 status idx8");
    access(0, 12'h160, 2'd0, 0, 1, 0, 1, 3'd0, 0, 32'h0000_00B8, "R5 status idx22");
    access(1, 12'h160, 2'd0, 32'h0000_0002, 0, 1, 1, 3'd0, 0, 0, "R5 control write");
    access(0, 12'h080, 2'd2, 0, 0, 0, 0, 3'd0, 0, 32'hFFFF_FFFF, "R5 word refused");

    // R6 timing word
    access(1, 12'h200, 2'd2, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, "R6 timing write");
    access(0, 12'h200, 2'd2, 0, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, "R6 timing read");
    access(1, 12'h200, 2'd1, 32'h0000_1111, 0, 0, 0, 0, 0, 0, "R9 timing half write");
    access(0, 12'h204, 2'd2, 0, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, "R9 timing unchanged");
    access(0, 12'h200, 2'd0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, "R6 timing byte refused");

    // R9 unmapped
    access(0, 12'h090, 2'd0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, "R9 idx9 read");
    access(1, 12'h090, 2'd0, 32'h0000_0001, 0, 0, 0, 0, 0, 0, "R9 idx9 write");
    access(0, 12'hFF0, 2'd2, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, "R9 top index read");
    access(0, 12'h000, 2'd3, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, "R9 bad size code");

    // R8 / R7 interrupt lines
    @(negedge clk);
    dma_irq_in = 1'b1;
    #1 chk("R8 dma forward", {30'd0, dma_irq_out, drv_irq_out}, {30'd0, 2'b10});
    access(0, 12'h300, 2'd2, 0, 0, 0, 0, 0, 0, 32'h8000_0000, "R7 dma bit");
    @(negedge clk);
    drv_irq_in = 1'b1;
    #1 chk("R8 drv forward", {30'd0, dma_irq_out, drv_irq_out}, {30'd0, 2'b11});
    access(0, 12'h300, 2'd2, 0, 0, 0, 0, 0, 0, 32'hC000_0000, "R7 both bits");
    access(1, 12'h300, 2'd1, 32'h8000_0000, 0, 0, 0, 0, 0, 0, "R9 irq half write");
    access(0, 12'h300, 2'd2, 0, 0, 0, 0, 0, 0, 32'hC000_0000, "R9 irq unchanged");
    access(1, 12'h300, 2'd2, 32'h8000_0000, 0, 0, 0, 0, 0, 0, "R7 clear top");
    access(0, 12'h300, 2'd2, 0, 0, 0, 0, 0, 0, 32'h4000_0000, "R7 top cleared");
    access(1, 12'h300, 2'd2, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 0, "R7 other bits");
    access(0, 12'h300, 2'd2, 0, 0, 0, 0, 0, 0, 32'h4000_0000, "R7 other bits no effect");
    @(negedge clk);
    dma_irq_in = 1'b0; drv_irq_in = 1'b0;
    access(0, 12'h300, 2'd2, 0, 0, 0, 0, 0, 0, 32'h0000_0000, "R7 lines low");
    @(negedge clk);
    dma_irq_in = 1'b1;
    access(0, 12'h300, 2'd2, 0, 0, 0, 0, 0, 0, 32'h8000_0000, "R7 dma rises again");

    // R11 latency and back-pressure
    access(0, 12'h010, 2'd0, 0, 1, 0, 0, 3'd1, 0, 32'h0000_00B1, "R11 latency");
    @(negedge clk);
    chk("R11 response next cycle", {31'd0, rsp_valid}, 32'd1);
    @(posedge clk);
    #1 rsp_ready = 1'b0;
    access(0, 12'h020, 2'd0, 0, 1, 0, 0, 3'd2, 0, 32'h0000_00B2, "R11 stalled read");
    repeat (3) @(negedge clk);
    chk("R11 held valid", {30'd0, rsp_valid, req_ready}, {30'd0, 2'b10});
    chk("R11 held data", rsp_data, 32'h0000_00B2);
    @(posedge clk);
    #2 rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule